// File: doc/BRIEF.md
# Peak Ratio Bar-Graph Level Meter

This block grades how strong a filtered signal is compared with the signal that went into the filter, and shows the result as an eight-segment thermometer display. Each time the sample strobe is high it accepts one raw sample and one filtered sample. Both are 12-bit offset-binary values whose mid-scale point is 0x7FF. For each stream it keeps a held peak. Every WINDOW samples the held peak is cleared and restarted from the largest of the last DEPTH samples of that stream.

After each sample, the mid-scale offset is removed from both peaks and any negative result is forced to zero. The block then counts how many of eight fractional thresholds, k/9 for k = 1..8, the filtered peak strictly exceeds when scaled against the raw peak. The count is found by a binary search that tests one threshold per pipeline stage. It is shown on a registered LED bar as a thermometer pattern, so a filtered peak near the raw peak lights every segment and a strongly attenuated one lights none.

A typical use is to report whether a tone falls inside a filter's pass band. The filter and the LED drivers are outside the block.

Top module: `meter_ratio_bar`

## Requirements
- R1: A synchronous active-high reset sets the LED bar to 0x00, sets both held peaks to zero and loads the window counter with WINDOW.
- R2: Let d_raw and d_flt be the raw and filtered held peaks minus 0x7FF. A value of d_raw or d_flt that would be negative is taken as zero, so a peak at or below 0x7FF behaves as zero.
- R3: Threshold k, for k = 1..8, has the Q15 value floor(k*32768/9). These are 0x0E38, 0x1C71, 0x2AAA, 0x38E3, 0x471C, 0x5555, 0x638E and 0x71C7. Threshold k is passed only when d_flt > (d_raw * threshold_k) >> 15. Equality does not pass.
- R4: The LED bar shows (1 << n) - 1, where n is the number of thresholds passed: 0x00, 0x01, 0x03, 0x07, 0x0F, 0x1F, 0x3F, 0x7F or 0xFF. Bit 0 is the lowest segment.
- R5: The LED bar changes only on the fifth rising clock edge after the edge that accepts a sample, and at that edge it shows the code for the peaks as they stand after that sample.
- R6: Between clears, each held peak becomes the larger of its current value and the newly accepted sample of its stream, so it never decreases.
- R7: On the WINDOW-th accepted sample after reset, and on every WINDOW-th sample after that, each held peak is replaced by the largest of the last DEPTH samples of its stream, counting the current sample. Samples accepted before that clear but inside those DEPTH positions count.
- R8: At a clear, a sample older than the last DEPTH samples no longer affects the held peak, however large it was.
- R9: While the strobe is low, neither the peaks, the window counter nor, once the pipeline has drained, the LED bar change.
- R10: A new sample may be accepted on every clock cycle. Each one produces its own LED update, in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample strobe; both data inputs are taken while high |
| raw_smp | input | 12 | Raw (unfiltered) offset-binary sample |
| flt_smp | input | 12 | Filtered offset-binary sample |
| led_bar | output | 8 | Registered thermometer code, bit 0 lowest segment |

## Verification
A wrong held peak, window count or search decision shows at the LED bar five edges after the sample that caused it. When the mistake moves the ratio across a threshold, the pattern is off by one or more segments. An error in the window logic stays hidden until the next clear, at most WINDOW samples later. It then shows as a bar that fails to drop after a large old sample, or that drops too far because samples just before the clear were left out. The bench uses a short window and a shallow depth so that every clear boundary and every threshold edge, including exact equality, is reached within a few thousand cycles.

// File: rtl/meter_pkg.sv
package meter_pkg;

  // Fraction k/(n+1) of full scale in Q15, rounded toward zero.
  function automatic logic [15:0] thr_q15(input int k, input int n);
    return 16'((k * 32768) / (n + 1));
  endfunction

  // Mid-scale offset of an offset-binary word of width w.
  function automatic int mid_scale(input int w);
    return (1 << (w - 1)) - 1;
  endfunction

endpackage

// File: rtl/meter_window_ctl.sv
module meter_window_ctl #(
  parameter int DEPTH  = 128,
  parameter int WINDOW = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic smp_vld,
  output logic win_open,
  output logic win_close
);
  localparam int CNTW = $clog2(WINDOW + 1);

  logic [CNTW-1:0] cnt;

  // Start of the last DEPTH samples before a clear, and the clear itself.
  assign win_open  = smp_vld && (cnt == CNTW'(DEPTH));
  assign win_close = smp_vld && (cnt == CNTW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= CNTW'(WINDOW);
    end else if (smp_vld) begin
      if (cnt == CNTW'(1)) cnt <= CNTW'(WINDOW);
      else                 cnt <= cnt - CNTW'(1);
    end
  end
endmodule

// File: rtl/meter_peak_chan.sv
module meter_peak_chan #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_vld,
  input  logic          win_open,
  input  logic          win_close,
  input  logic [DW-1:0] smp,
  output logic [DW-1:0] peak
);
  logic [DW-1:0] shadow;
  logic [DW-1:0] shadow_n;
  logic [DW-1:0] grow_n;

  // The shadow collects the maximum of the samples that fall inside the
  // final DEPTH positions before the next clear.
  always_comb begin
    if (win_open)          shadow_n = smp;
    else if (smp > shadow) shadow_n = smp;
    else                   shadow_n = shadow;
    grow_n = (smp > peak) ? smp : peak;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      peak   <= '0;
    end else if (smp_vld) begin
      shadow <= shadow_n;
      peak   <= win_close ? shadow_n : grow_n;
    end
  end
endmodule

// File: rtl/meter_search_stage.sv
module meter_search_stage
  import meter_pkg::*;
#(
  parameter int DW   = 12,
  parameter int NTHR = 8,
  parameter int CW   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [CW-1:0] in_lo,
  input  logic [CW-1:0] in_hi,
  input  logic [DW-1:0] in_din,
  input  logic [DW-1:0] in_dout,
  output logic          out_vld,
  output logic [CW-1:0] out_lo,
  output logic [CW-1:0] out_hi,
  output logic [DW-1:0] out_din,
  output logic [DW-1:0] out_dout
);
  localparam int PW = DW + 16;

  logic [15:0]   tab [NTHR+1];
  logic [CW:0]   sum;
  logic [CW-1:0] k_sel;
  logic [PW-1:0] prod;
  logic [DW-1:0] scaled;
  logic          pass;
  logic [CW-1:0] lo_n;
  logic [CW-1:0] hi_n;

  for (genvar k = 0; k <= NTHR; k++) begin : g_tab
    assign tab[k] = thr_q15(k, NTHR);
  end

  always_comb begin
    sum = {1'b0, in_lo} + {1'b0, in_hi} + (CW+1)'(1);
    // A span of three outcomes tests its top threshold first.
    if ((in_hi - in_lo) == CW'(2)) k_sel = in_hi;
    else                           k_sel = sum[CW:1];
    prod   = PW'(in_din) * PW'(tab[k_sel]);
    scaled = prod[DW+14:15];
    pass   = in_dout > scaled;
    if (in_lo == in_hi) begin
      lo_n = in_lo;
      hi_n = in_hi;
    end else if (pass) begin
      lo_n = k_sel;
      hi_n = in_hi;
    end else begin
      lo_n = in_lo;
      hi_n = k_sel - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_lo   <= '0;
      out_hi   <= '0;
      out_din  <= '0;
      out_dout <= '0;
    end else begin
      out_vld  <= in_vld;
      out_lo   <= lo_n;
      out_hi   <= hi_n;
      out_din  <= in_din;
      out_dout <= in_dout;
    end
  end
endmodule

// File: rtl/meter_ratio_bar.sv
module meter_ratio_bar
  import meter_pkg::*;
#(
  parameter int DW     = 12,
  parameter int DEPTH  = 128,
  parameter int WINDOW = 500,
  parameter int NTHR   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            smp_vld,
  input  logic [DW-1:0]   raw_smp,
  input  logic [DW-1:0]   flt_smp,
  output logic [NTHR-1:0] led_bar
);
  localparam int CW     = $clog2(NTHR + 1);
  localparam int LEVELS = $clog2(NTHR + 1);
  localparam logic [DW-1:0] OFS = DW'(mid_scale(DW));

  logic          win_open;
  logic          win_close;
  logic [DW-1:0] chan_smp [2];
  logic [DW-1:0] chan_pk  [2];
  logic [DW-1:0] pk_raw;
  logic [DW-1:0] pk_flt;
  logic          pk_vld;

  logic          st_vld  [LEVELS+1];
  logic [CW-1:0] st_lo   [LEVELS+1];
  logic [CW-1:0] st_hi   [LEVELS+1];
  logic [DW-1:0] st_din  [LEVELS+1];
  logic [DW-1:0] st_dout [LEVELS+1];
  logic          res_vld;
  logic [NTHR-1:0] led_n;

  meter_window_ctl #(.DEPTH(DEPTH), .WINDOW(WINDOW)) u_win (
    .clk      (clk),
    .rst      (rst),
    .smp_vld  (smp_vld),
    .win_open (win_open),
    .win_close(win_close)
  );

  assign chan_smp[0] = raw_smp;
  assign chan_smp[1] = flt_smp;

  for (genvar c = 0; c < 2; c++) begin : g_chan
    meter_peak_chan #(.DW(DW)) u_peak (
      .clk      (clk),
      .rst      (rst),
      .smp_vld  (smp_vld),
      .win_open (win_open),
      .win_close(win_close),
      .smp      (chan_smp[c]),
      .peak     (chan_pk[c])
    );
  end

  assign pk_raw = chan_pk[0];
  assign pk_flt = chan_pk[1];

  always_ff @(posedge clk) begin
    if (rst) pk_vld <= 1'b0;
    else     pk_vld <= smp_vld;
  end

  // Offset removal with a floor at zero feeds the first search level.
  assign st_vld[0]  = pk_vld;
  assign st_lo[0]   = '0;
  assign st_hi[0]   = CW'(NTHR);
  assign st_din[0]  = (pk_raw > OFS) ? (pk_raw - OFS) : '0;
  assign st_dout[0] = (pk_flt > OFS) ? (pk_flt - OFS) : '0;

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    meter_search_stage #(.DW(DW), .NTHR(NTHR), .CW(CW)) u_stage (
      .clk     (clk),
      .rst     (rst),
      .in_vld  (st_vld[l]),
      .in_lo   (st_lo[l]),
      .in_hi   (st_hi[l]),
      .in_din  (st_din[l]),
      .in_dout (st_dout[l]),
      .out_vld (st_vld[l+1]),
      .out_lo  (st_lo[l+1]),
      .out_hi  (st_hi[l+1]),
      .out_din (st_din[l+1]),
      .out_dout(st_dout[l+1])
    );
  end

  assign res_vld = st_vld[LEVELS];

  always_comb begin
    for (int i = 0; i < NTHR; i++) led_n[i] = st_lo[LEVELS] > CW'(i);
  end

  always_ff @(posedge clk) begin
    if (rst)          led_bar <= '0;
    else if (res_vld) led_bar <= led_n;
  end
endmodule

// File: rtl/meter_ratio_bar_chk.sv
module meter_ratio_bar_chk #(
  parameter int DW   = 12,
  parameter int NTHR = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            smp_vld,
  input logic [DW-1:0]   raw_smp,
  input logic [DW-1:0]   flt_smp,
  input logic            win_close,
  input logic [DW-1:0]   pk_raw,
  input logic [DW-1:0]   pk_flt,
  input logic [NTHR-1:0] led_bar
);
  localparam int LAT = $clog2(NTHR + 1) + 1;
  localparam int IW  = $clog2(LAT + 1);

  logic [IW-1:0] idle_cnt;

  always_ff @(posedge clk) begin
    if (rst)                        idle_cnt <= IW'(LAT);
    else if (smp_vld)               idle_cnt <= '0;
    else if (idle_cnt < IW'(LAT))   idle_cnt <= idle_cnt + IW'(1);
  end

  // R1
  reset_dark_chk: assert property (@(posedge clk) rst |=> led_bar == '0);

  // R4
  thermo_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (led_bar & (led_bar + 1'b1)) == '0);

  // R6
  raw_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !win_close) |=> pk_raw >= $past(pk_raw));

  // R6
  flt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !win_close) |=> pk_flt >= $past(pk_flt));

  // R7
  raw_cover_chk: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> pk_raw >= $past(raw_smp));

  // R7
  flt_cover_chk: assert property (@(posedge clk) disable iff (rst)
    smp_vld |=> pk_flt >= $past(flt_smp));

  // R9
  quiet_bar_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_cnt >= IW'(LAT)) |=> $stable(led_bar));

  // R9
  quiet_peak_chk: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> ($stable(pk_raw) && $stable(pk_flt)));
endmodule

bind meter_ratio_bar meter_ratio_bar_chk #(.DW(DW), .NTHR(NTHR)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .smp_vld  (smp_vld),
  .raw_smp  (raw_smp),
  .flt_smp  (flt_smp),
  .win_close(win_close),
  .pk_raw   (pk_raw),
  .pk_flt   (pk_flt),
  .led_bar  (led_bar)
);

// File: tb/meter_ratio_bar_tb.sv
`timescale 1ns/1ps
module meter_ratio_bar_tb;
  localparam int DW    = 12;
  localparam int DEPTH = 8;
  localparam int WIN   = 20;
  localparam int NTHR  = 8;
  localparam int LAT   = 5;
  localparam int OFS   = 2047;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       smp_vld = 1'b0;
  logic [11:0] raw_smp = '0;
  logic [11:0] flt_smp = '0;
  logic [7:0]  led_bar;

  int errors = 0;
  int checks = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;
  string tag = "R1";

  always #2 clk = ~clk;

  meter_ratio_bar #(.DW(DW), .DEPTH(DEPTH), .WINDOW(WIN), .NTHR(NTHR)) u_dut (
    .clk    (clk),
    .rst    (rst),
    .smp_vld(smp_vld),
    .raw_smp(raw_smp),
    .flt_smp(flt_smp),
    .led_bar(led_bar)
  );

  // Reference: literal history buffers, rescanned after every sample.
  int   m_cnt;
  int   h_raw [DEPTH];
  int   h_flt [DEPTH];
  int   m_pr, m_pf;
  logic p_v [LAT];
  logic [7:0] p_c [LAT];
  logic [7:0] exp_led;

  function automatic logic [7:0] ref_code(input int pr, input int pf);
    int din, dout, n, thr, lim;
    din  = (pr > OFS) ? pr - OFS : 0;
    dout = (pf > OFS) ? pf - OFS : 0;
    n = 0;
    for (int k = 1; k <= NTHR; k++) begin
      thr = (k * 32768) / (NTHR + 1);
      lim = (din * thr) >> 15;
      if (dout > lim) n++;
    end
    return 8'((1 << n) - 1);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = WIN; m_pr = 0; m_pf = 0; exp_led = '0;
      for (int i = 0; i < DEPTH; i++) begin h_raw[i] = 0; h_flt[i] = 0; end
      for (int i = 0; i < LAT; i++) begin p_v[i] = 1'b0; p_c[i] = '0; end
    end else begin
      if (p_v[LAT-1]) exp_led = p_c[LAT-1];
      for (int i = LAT-1; i > 0; i--) begin p_v[i] = p_v[i-1]; p_c[i] = p_c[i-1]; end
      p_v[0] = 1'b0;
      if (smp_vld) begin
        for (int i = DEPTH-1; i > 0; i--) begin h_raw[i] = h_raw[i-1]; h_flt[i] = h_flt[i-1]; end
        h_raw[0] = int'(raw_smp);
        h_flt[0] = int'(flt_smp);
        m_cnt--;
        if (m_cnt == 0) begin m_cnt = WIN; m_pr = 0; m_pf = 0; end
        for (int i = 0; i < DEPTH; i++) begin
          if (h_raw[i] > m_pr) m_pr = h_raw[i];
          if (h_flt[i] > m_pf) m_pf = h_flt[i];
        end
        p_v[0] = 1'b1;
        p_c[0] = ref_code(m_pr, m_pf);
      end
    end
  end

  always @(negedge clk) begin
    if (chk_en && !done) begin
      checks++;
      if (led_bar !== exp_led) begin
        errors++;
        $display("FAIL %s: led_bar=%h expected %h at %0t", tag, led_bar, exp_led, $time);
      end
    end
  end

  task automatic send(input int a, input int b);
    @(negedge clk);
    smp_vld = 1'b1;
    raw_smp = 12'(a);
    flt_smp = 12'(b);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      smp_vld = 1'b0;
    end
  endtask

  task automatic settle(input int a, input int b);
    repeat (2 * WIN) send(a, b);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    int lfsr;
    int dins [5];
    dins = '{2048, 1024, 300, 9, 1};
    lfsr = 16'hACE1;

    tag = "R1 reset";
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_en = 1'b1;
    idle(4);

    tag = "R9 idle after reset";
    idle(20);

    // Full sweep of the filtered peak against the largest raw peak.
    tag = "R3/R4/R10 sweep din=2048";
    settle(12'hFFF, OFS);
    for (int v = OFS; v <= 12'hFFF; v++) send(12'hFFF, v);
    idle(LAT + 2);

    tag = "R3/R4 sweep small din";
    foreach (dins[j]) begin
      settle(OFS + dins[j], OFS);
      for (int v = OFS; v <= OFS + dins[j] + 4 && v <= 12'hFFF; v++) send(OFS + dins[j], v);
      idle(LAT + 1);
    end

    tag = "R2 clamp below offset";
    settle(OFS, OFS);
    send(OFS, OFS + 1);
    settle(12'h300, 12'h7F0);
    settle(12'h300, 12'h100);
    settle(12'h100, 12'h800);
    for (int v = 0; v < 12'h900; v += 16'h55) send(12'h200, v);
    idle(LAT + 1);

    tag = "R6 hold on falling input";
    settle(12'hC00, OFS);
    for (int v = 12'hFFF; v > 12'h900; v -= 16'h40) send(12'hC00, v);
    idle(LAT + 1);

    tag = "R8 old spike dropped";
    settle(12'hFFF, 12'h900);
    send(12'hFFF, 12'hFFF);
    repeat (2 * WIN) send(12'hFFF, 12'h900);
    idle(LAT + 1);

    tag = "R7 random back-to-back";
    for (int i = 0; i < 600; i++) begin
      lfsr = ((lfsr >> 1) ^ ((lfsr & 1) != 0 ? 16'hB400 : 0)) & 16'hFFFF;
      send(12'hA00 + (lfsr & 12'h3FF), lfsr >> 4);
    end

    tag = "R5 spaced samples";
    for (int i = 0; i < 300; i++) begin
      lfsr = ((lfsr >> 1) ^ ((lfsr & 1) != 0 ? 16'hB400 : 0)) & 16'hFFFF;
      send(lfsr & 12'hFFF, (lfsr >> 3) & 12'hFFF);
      idle(lfsr % 7);
    end
    idle(LAT + 2);

    tag = "R1 reset mid-run";
    settle(12'hFFF, 12'hFFF);
    @(negedge clk);
    smp_vld = 1'b0;
    rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(LAT + 2);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL %s watchdog: run still active after 200000 cycles, expected completion", tag);
      done = 1'b1;
      finish_run();
    end
  end
endmodule